// File: doc/BRIEF.md
# Power-good strap latch controller

This block sits between a shared strobe pin and the clock-generator logic that depends on board straps. Until the power-good strobe (active low) is seen low, the strap inputs mean nothing and every decoded output stays at its reset value. The block samples three frequency-select bits, a test-select bit and a debug-clock select bit once, when the strobe is first seen low. From then on the same pin acts as an active-high request to power down.

The strobe and the straps pass through a two-flop synchronizer. A low only counts when two consecutive synchronized samples are low, so a one-cycle glitch does nothing. After the capture, the block drives:
- the raw latched straps;
- a CPU frequency index in ascending speed order, decoded from a non-binary strap code, with a flag for the unused code;
- a global tristate for test mode;
- the select for the shared output pair, which carries either the CPU debug clock or an extra SRC clock;
- the synchronized power-down level.

In test mode the one-shot rule is lifted. Each qualified low reloads all straps, so test mode can also be left by reloading the test select as 0.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `latched`, `fs_q`, `freq_code`, `freq_rsvd`, `out_tristate`, `dbg_clk_sel` and `pd_req` are all 0.
- R2: Let the first rising clock edge that samples `pwrgd_pd_in` low be edge 1. If the pin is also low at edge 2, `latched` is 1 after edge 4 and 0 before it. A low seen at only one edge never sets `latched`. Once `latched` is 1 it stays 1 until reset.
- R3: `fs_q` holds the captured straps as {fs_c, fs_b, fs_a} = `fs_in[2:0]`. `freq_code` gives the CPU speed as an index: 101→0 (100 MHz), 001→1 (133), 011→2 (166), 010→3 (200), 000→4 (266), 100→5 (333), 110→6 (400).
- R4: A captured code of 111 gives `freq_code` = 7 and `freq_rsvd` = 1. Every other code gives `freq_rsvd` = 0.
- R5: A captured `test_sel_in` of 1 drives `out_tristate` to 1 and holds `pd_req` at 0 whatever the pin level. A captured 0 gives `out_tristate` = 0.
- R6: `dbg_clk_sel` is 1 when the captured `dbg_sel_in` is 1, which selects the CPU debug clock. It is 0 when the captured value is 0, which selects the extra SRC clock.
- R7: Outside test mode, once `latched` is 1, changes on the strap inputs and further lows on the pin leave `fs_q`, `freq_code`, `dbg_clk_sel` and `out_tristate` unchanged.
- R8: Once `latched` is 1 and outside test mode, `pd_req` follows the pin level with a delay of two clock edges. A change sampled at edge p shows on `pd_req` after edge p+1.
- R9: In test mode, a qualified low on the pin reloads all five straps. Reloading the test select as 0 leaves test mode, and after that the pin again acts as the power-down request.
- R10: Before `latched` is 1, the decoded outputs stay at 0 whatever the strap inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_pd_in | input | 1 | Shared pin: power-good strobe (active low) before capture, power-down request (active high) after it |
| fs_in | input | 3 | Frequency-select straps {c, b, a} |
| test_sel_in | input | 1 | Test-mode strap |
| dbg_sel_in | input | 1 | Debug-clock select strap |
| latched | output | 1 | Straps have been captured |
| fs_q | output | 3 | Captured frequency-select straps |
| freq_code | output | 3 | Decoded CPU speed index |
| freq_rsvd | output | 1 | Captured code is the unused one |
| out_tristate | output | 1 | Tristate all clock outputs (test mode) |
| dbg_clk_sel | output | 1 | Shared pair carries the debug clock |
| pd_req | output | 1 | Synchronized power-down request |

## Verification
The pin's two meanings overlap in time. In test mode the pin is still a strobe, and releasing it is also the moment it could request power down. The bench enters test mode, drives the pin high and judges that `pd_req` stays 0 while `out_tristate` stays 1. It then holds the pin low, reloads the test select as 0, raises the pin, and judges that `pd_req` rises exactly two edges later. A second overlap is checked outside test mode: a fresh low on the pin, together with changed straps, is sent after the capture, and the bench confirms that it only ends the power-down request and reloads nothing.

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrgd_pd_in,
  input  logic [2:0] fs_in,
  input  logic       test_sel_in,
  input  logic       dbg_sel_in,
  output logic       latched,
  output logic [2:0] fs_q,
  output logic [2:0] freq_code,
  output logic       freq_rsvd,
  output logic       out_tristate,
  output logic       dbg_clk_sel,
  output logic       pd_req
);
  localparam int STRAP_W = 5;

  logic [1:0]         pin_sync;
  logic               pin_prev;
  logic [STRAP_W-1:0] strap_s1, strap_s2, straps;
  logic               seen;
  logic               low_ok;
  logic               test_on;
  logic [2:0]         code;

  assign low_ok  = !pin_sync[1] && !pin_prev;
  assign test_on = straps[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync <= 2'b11;
      pin_prev <= 1'b1;
      strap_s1 <= '0;
      strap_s2 <= '0;
      straps   <= '0;
      seen     <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[0], pwrgd_pd_in};
      pin_prev <= pin_sync[1];
      strap_s1 <= {dbg_sel_in, test_sel_in, fs_in};
      strap_s2 <= strap_s1;
      if (low_ok && (!seen || test_on)) begin
        seen   <= 1'b1;
        straps <= strap_s2;
      end
    end
  end

  always_comb begin
    case (straps[2:0])
      3'b101:  code = 3'd0;
      3'b001:  code = 3'd1;
      3'b011:  code = 3'd2;
      3'b010:  code = 3'd3;
      3'b000:  code = 3'd4;
      3'b100:  code = 3'd5;
      3'b110:  code = 3'd6;
      default: code = 3'd7;
    endcase
  end

  assign latched      = seen;
  assign fs_q         = straps[2:0];
  assign freq_code    = seen ? code : 3'd0;
  assign freq_rsvd    = seen && (straps[2:0] == 3'b111);
  assign out_tristate = seen && test_on;
  assign dbg_clk_sel  = seen && straps[4];
  assign pd_req       = seen && !test_on && pin_sync[1];
endmodule

// File: rtl/strap_latch_ctrl_chk.sv
module strap_latch_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       latched,
  input logic [2:0] fs_q,
  input logic [2:0] freq_code,
  input logic       freq_rsvd,
  input logic       out_tristate,
  input logic       dbg_clk_sel,
  input logic       pd_req
);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> latched);

  p_rsvd_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    freq_rsvd |-> (freq_code == 3'd7));

  p_no_pd_in_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_tristate |-> !pd_req);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !out_tristate) |=> ($stable(fs_q) && $stable(dbg_clk_sel) && $stable(freq_code)));

  p_idle_before_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !latched |-> (freq_code == 3'd0 && !freq_rsvd && !out_tristate && !dbg_clk_sel && !pd_req));
endmodule

bind strap_latch_ctrl strap_latch_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .latched(latched), .fs_q(fs_q),
  .freq_code(freq_code), .freq_rsvd(freq_rsvd), .out_tristate(out_tristate),
  .dbg_clk_sel(dbg_clk_sel), .pd_req(pd_req)
);

// File: tb/test_strap_latch_ctrl.sv
module test_strap_latch_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b1, tsel = 1'b0, dsel = 1'b0;
  logic [2:0] fs = 3'b000;
  logic latched, frsvd, otri, dclk, pdr;
  logic [2:0] fsq, fcode;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  strap_latch_ctrl i_strap_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrgd_pd_in(pin), .fs_in(fs),
    .test_sel_in(tsel), .dbg_sel_in(dsel), .latched(latched), .fs_q(fsq),
    .freq_code(fcode), .freq_rsvd(frsvd), .out_tristate(otri),
    .dbg_clk_sel(dclk), .pd_req(pdr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_code(logic [2:0] c);
    case (c)
      3'b101: return 0; 3'b001: return 1; 3'b011: return 2; 3'b010: return 3;
      3'b000: return 4; 3'b100: return 5; 3'b110: return 6; default: return 7;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin = 1'b1; fs = 3'b000; tsel = 1'b0; dsel = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(1);
  endtask

  task automatic power_up(logic [2:0] f, logic t, logic d);
    do_reset();
    fs = f; tsel = t; dsel = d;
    cycles(3);
    pin = 1'b0;
    cycles(6);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 latched", latched, 0);
    check("R1 fs_q", fsq, 0);
    check("R1 pd_req", pdr, 0);
    fs = 3'b111; tsel = 1'b1; dsel = 1'b1;
    cycles(5);
    check("R10 freq_code", fcode, 0);
    check("R10 freq_rsvd", frsvd, 0);
    check("R10 out_tristate", otri, 0);
    check("R10 dbg_clk_sel", dclk, 0);
  endtask

  task automatic t_glitch();
    do_reset();
    pin = 1'b0;
    cycles(1);
    pin = 1'b1;
    cycles(6);
    check("R2 glitch ignored", latched, 0);
  endtask

  task automatic t_timing();
    do_reset();
    fs = 3'b010;
    cycles(3);
    pin = 1'b0;
    cycles(3);
    check("R2 not yet after edge 3", latched, 0);
    cycles(1);
    check("R2 set after edge 4", latched, 1);
    pin = 1'b1;
    cycles(4);
    check("R2 sticky", latched, 1);
  endtask

  task automatic t_decode();
    for (int c = 0; c < 8; c++) begin
      power_up(c[2:0], 1'b0, 1'b0);
      check("R3 fs_q", fsq, c);
      check("R3 freq_code", fcode, exp_code(c[2:0]));
      check("R4 freq_rsvd", frsvd, (c == 7) ? 1 : 0);
    end
  endtask

  task automatic t_dbg();
    power_up(3'b101, 1'b0, 1'b1);
    check("R6 debug selected", dclk, 1);
    check("R5 normal mode", otri, 0);
    power_up(3'b101, 1'b0, 1'b0);
    check("R6 src selected", dclk, 0);
  endtask

  task automatic t_ignore_and_pd();
    power_up(3'b001, 1'b0, 1'b0);
    pin = 1'b1;
    cycles(1);
    check("R8 pd not yet", pdr, 0);
    cycles(1);
    check("R8 pd asserted", pdr, 1);
    fs = 3'b110; dsel = 1'b1; tsel = 1'b1;
    cycles(3);
    pin = 1'b0;
    cycles(2);
    check("R8 pd released", pdr, 0);
    cycles(4);
    check("R7 fs_q kept", fsq, 3'b001);
    check("R7 freq_code kept", fcode, 1);
    check("R7 dbg_clk_sel kept", dclk, 0);
    check("R7 out_tristate kept", otri, 0);
  endtask

  task automatic t_test_mode();
    power_up(3'b011, 1'b1, 1'b0);
    check("R5 tristate", otri, 1);
    pin = 1'b1;
    cycles(4);
    check("R5 no pd in test", pdr, 0);
    check("R5 tristate held", otri, 1);
    fs = 3'b100;
    cycles(2);
    pin = 1'b0;
    cycles(6);
    check("R9 reload fs_q", fsq, 3'b100);
    check("R9 reload code", fcode, 5);
    tsel = 1'b0;
    cycles(5);
    check("R9 test exited", otri, 0);
    pin = 1'b1;
    cycles(1);
    check("R9 pd not yet", pdr, 0);
    cycles(1);
    check("R9 pd after exit", pdr, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_glitch();
    t_timing();
    t_decode();
    t_dbg();
    t_ignore_and_pd();
    t_test_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule